// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Coherent Split Read

The block is a 12-bit counter that advances once per microsecond and runs without stopping. A divide-by-6 prescaler turns the 6 MHz system clock into a 1 MHz tick. The counter wraps from its maximum back to zero. It has no load, stop or reload control.

Software reads the count over a byte-wide read path in two steps. A read of the low byte returns bits 7:0. In the same clock edge it copies bits 11:8 into a shadow register. A later read of the high nibble returns that shadow copy, not the live upper bits. The two halves therefore always belong to the same count value, even when the counter carries between the two reads.

Two tap outputs feed an interrupt controller. Each gives a one-cycle pulse when its counter bit goes from 0 to 1. Bit 7 rises every 256 µs, and a rise marks the count reaching 128 within each 256 µs span. Bit 10 rises every 2048 µs, when the count reaches 1024 within each 2048 µs span.

Top module: `usec_timer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, rd_data_o is 0 and both tap outputs are 0. The prescaler and the counter reset to 0.
- R2: The counter advances by exactly one on every 6th clock edge after reset is released. After n edges the count is floor(n/6) mod 4096.
- R3: The counter wraps from 4095 to 0 with no other effect.
- R4: A read with rd_en_i=1 and rd_sel_i=0 (low byte) puts the count's bits 7:0 on rd_data_o at the next clock edge. The count used is the one held before that edge.
- R5: A low-byte read copies the count's bits 11:8 into the shadow register. A read with rd_en_i=1 and rd_sel_i=1 (high nibble) puts {4'b0, shadow} on rd_data_o at the next edge, whatever the live upper bits are.
- R6: When a low-byte read and a counter increment fall on the same edge, both the low byte and the shadow take the value before the increment.
- R7: tap_fast_o is high for exactly one cycle each time counter bit 7 goes from 0 to 1, and is low otherwise.
- R8: tap_slow_o is high for exactly one cycle each time counter bit 10 goes from 0 to 1, and is low otherwise.
- R9: rd_data_o holds its value in every cycle with rd_en_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 6 MHz system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rd_sel_i | input | 1 | 0 selects the low byte, 1 selects the high nibble |
| rd_data_o | output | 8 | Registered read data |
| tap_fast_o | output | 1 | One-cycle pulse when count bit 7 rises |
| tap_slow_o | output | 1 | One-cycle pulse when count bit 10 rises |

## Verification
A wrong prescaler phase or a wrong counter value is not visible directly. It shows up one cycle after the next read, as a low byte that differs from floor(n/6). It also shows up as a tap pulse that comes early or late, at the latest within 256 µs. A shadow that follows the live counter instead of holding its copy shows up only across a carry. The bench therefore reads exactly on the edges where 0x0FF and 0xFFF increment, and compares the later high-nibble read with the copied value. Tap timing is compared on every cycle over a full wrap of the counter.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic {
    SEL_LO = 1'b0,
    SEL_HI = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == PW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wrap_counter.sv
module wrap_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/split_read.sv
module split_read
  import timer_pkg::*;
#(
  parameter int W    = 12,
  parameter int LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_en_i,
  input  logic            rd_sel_i,
  input  logic [W-1:0]    cnt_i,
  output logic [LO_W-1:0] rd_data_o,
  output logic [W-LO_W-1:0] shadow_o
);
  localparam int HI_W = W - LO_W;

  // cnt_i is the pre-edge value, so a read on an increment edge stays coherent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      shadow_o  <= '0;
    end else if (rd_en_i) begin
      if (rd_sel_e'(rd_sel_i) == SEL_LO) begin
        rd_data_o <= cnt_i[LO_W-1:0];
        shadow_o  <= cnt_i[W-1:LO_W];
      end else begin
        rd_data_o <= LO_W'(shadow_o);
      end
    end
  end

  initial begin
    if (HI_W < 1 || HI_W > LO_W) $error("split_read: bad width split");
  end
endmodule

// File: rtl/rise_pulse.sv
module rise_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign pulse_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/usec_timer.sv
module usec_timer #(
  parameter int DIV      = 6,
  parameter int CNT_W    = 12,
  parameter int LO_W     = 8,
  parameter int TAP_FAST = 7,
  parameter int TAP_SLOW = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_en_i,
  input  logic            rd_sel_i,
  output logic [LO_W-1:0] rd_data_o,
  output logic            tap_fast_o,
  output logic            tap_slow_o
);
  localparam int HI_W   = CNT_W - LO_W;
  localparam int N_TAPS = 2;
  localparam int TAP_BIT [N_TAPS] = '{TAP_FAST, TAP_SLOW};

  logic              tick;
  logic [CNT_W-1:0]  cnt_q;
  logic [HI_W-1:0]   shadow;
  logic [N_TAPS-1:0] taps;

  tick_prescaler #(.DIV(DIV)) i_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  wrap_counter #(.W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (tick),
    .cnt_o (cnt_q)
  );

  split_read #(.W(CNT_W), .LO_W(LO_W)) i_rd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en_i),
    .rd_sel_i (rd_sel_i),
    .cnt_i    (cnt_q),
    .rd_data_o(rd_data_o),
    .shadow_o (shadow)
  );

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    rise_pulse i_rise (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (cnt_q[TAP_BIT[g]]),
      .pulse_o(taps[g])
    );
  end

  assign tap_fast_o = taps[0];
  assign tap_slow_o = taps[1];
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
  parameter int CNT_W = 12,
  parameter int LO_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [CNT_W-LO_W-1:0] shadow_i,
  input logic               rd_en_i,
  input logic               rd_sel_i,
  input logic [LO_W-1:0]    rd_data_i,
  input logic               tap_fast_i,
  input logic               tap_slow_i
);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1));

  a_r4_low_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_sel_i) |=> rd_data_i == $past(cnt_i[LO_W-1:0]));

  a_r5_high_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_sel_i) |=> rd_data_i == LO_W'($past(shadow_i)));

  a_r7_fast_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_fast_i |=> !tap_fast_i);

  a_r8_slow_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_slow_i |=> !tap_slow_i);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_i));
endmodule

bind usec_timer usec_timer_chk #(.CNT_W(CNT_W), .LO_W(LO_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick),
  .cnt_i     (cnt_q),
  .shadow_i  (shadow),
  .rd_en_i   (rd_en_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_i (rd_data_o),
  .tap_fast_i(tap_fast_o),
  .tap_slow_i(tap_slow_o)
);

// File: tb/test_usec_timer.sv
module test_usec_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 6;
  localparam int MOD = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       tap_fast, tap_slow;

  int n = 0;
  int checks = 0;
  int errors = 0;
  int shadow_m = 0;
  bit done = 0;
  bit tap_on = 0;

  usec_timer i_usec_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .rd_en_i   (rd_en),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_data),
    .tap_fast_o(tap_fast),
    .tap_slow_o(tap_slow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rst_n) n = n + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cnt_now();
    return (n / DIV) % MOD;
  endfunction

  // R7 R8: tap pulses compared every cycle
  always @(negedge clk) begin
    if (tap_on) begin
      int c;
      bit ef, es;
      c  = cnt_now();
      ef = (n % DIV == 0) && (n != 0) && (c % 256 == 128);
      es = (n % DIV == 0) && (n != 0) && (c % 2048 == 1024);
      chk(tap_fast == ef, "R7 tap_fast", int'(tap_fast), int'(ef));
      chk(tap_slow == es, "R8 tap_slow", int'(tap_slow), int'(es));
    end
  end

  // called at a negedge; returns at the negedge after the read edge
  task automatic do_read(bit hi, string req);
    int exp;
    if (!hi) begin
      exp = cnt_now() % 256;
      shadow_m = cnt_now() / 256;
    end else begin
      exp = shadow_m;
    end
    rd_en = 1'b1;
    rd_sel = hi;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == 8'(exp), req, int'(rd_data), exp);
  endtask

  task automatic wait_point(int c, int ph);
    while (!(cnt_now() == c && n % DIV == ph)) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_data == 8'd0, "R1 rd_data in reset", int'(rd_data), 0);
    chk(!tap_fast && !tap_slow, "R1 taps in reset", int'({tap_fast, tap_slow}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'd0, "R1 rd_data after reset", int'(rd_data), 0);
    chk(!tap_fast && !tap_slow, "R1 taps after reset", int'({tap_fast, tap_slow}), 0);
    tap_on = 1;

    // R2 R4 R5: reads at every prescaler phase
    for (int i = 0; i < 48; i++) begin
      repeat (i % 7 + 1) @(negedge clk);
      do_read(1'b0, "R2 R4 low byte");
      repeat (i % 3) @(negedge clk);
      do_read(1'b1, "R5 high nibble");
    end

    // R6: low read on the edge where 0x0FF becomes 0x100
    wait_point(255, DIV - 1);
    do_read(1'b0, "R6 low byte at carry");
    chk(shadow_m == 0, "R6 model shadow", shadow_m, 0);
    repeat (12) @(negedge clk);
    do_read(1'b1, "R6 R5 high nibble keeps pre-carry copy");

    // R9: held data without reads
    begin
      logic [7:0] held;
      held = rd_data;
      repeat (20) begin
        @(negedge clk);
        chk(rd_data == held, "R9 hold", int'(rd_data), int'(held));
      end
    end

    wait_point(1500, 3);
    do_read(1'b0, "R4 low byte mid-range");
    do_read(1'b1, "R5 high nibble mid-range");

    // R3 R6: read on the wrap edge
    wait_point(MOD - 1, DIV - 1);
    do_read(1'b0, "R3 R6 low byte at wrap");
    chk(shadow_m == 15, "R3 model shadow", shadow_m, 15);
    repeat (8) @(negedge clk);
    chk(cnt_now() < 4, "R3 model wrapped", cnt_now(), 0);
    do_read(1'b1, "R3 R5 high nibble after wrap");
    do_read(1'b0, "R3 low byte after wrap");
    do_read(1'b1, "R3 high nibble after wrap");

    wait_point(130, 0);
    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule